// File: doc/BRIEF.md
# Banked Direct Data Address Generator

This block turns the 8-bit operand field of a direct-addressing instruction into a 12-bit data-memory address. The 4 KB data space is split into 16 pages of 256 bytes; page 15 holds the special-function registers in its upper half, at 0xF80 to 0xFFF. One mode bit, supplied with each instruction, picks how the page is found.

With the mode bit clear, a fixed shortcut window is used. Operand values 0x00 to 0x7F reach the bottom of page 0. Operand values 0x80 to 0xFF reach the special-function region at the top of page 15. With the mode bit set, the page number comes from the low nibble of an 8-bit page-select register that software loads. The register's upper nibble is kept but takes no part in forming addresses.

The address is combinational from the operand, the mode bit and the registered page select. A load of the register is seen by addresses from the following cycle on.

Top module: `bank_addr_gen`

## Requirements
- R1: After reset, `page_q` reads 0x00, so with `page_mode` = 1 the address is 0x000 followed by the operand (operand 0x12 gives 0x012).
- R2: With `page_mode` = 0 and `file_field` below 0x80, `data_addr` equals 0x000 + `file_field`.
- R3: With `page_mode` = 0 and `file_field` at 0x80 or above, `data_addr` equals 0xF00 + `file_field`, which lies in 0xF80..0xFFF.
- R4: With `page_mode` = 1, `data_addr` is `page_q[3:0]` in bits 11:8 and `file_field` in bits 7:0.
- R5: When `page_wr` is 1 at a rising clock edge, `page_q` takes `page_wdata`. Addresses formed in the same cycle as the load still use the old page, and addresses from the next cycle on use the new one.
- R6: Bits 7:4 of the page register are stored and read back on `page_q`, but they have no effect on `data_addr`.
- R7: With `page_wr` at 0, `page_q` keeps its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| file_field | input | 8 | Operand field of the instruction |
| page_mode | input | 1 | 0: shortcut window, 1: page register selects the page |
| page_wr | input | 1 | Load strobe for the page register |
| page_wdata | input | 8 | Value loaded into the page register |
| data_addr | output | 12 | Data-memory address |
| page_q | output | 8 | Current page register contents |

## Verification
The assertions assume that `page_wr`, `page_wdata`, `file_field` and `page_mode` hold known values at every rising edge after reset is released. They also assume that register state is judged only after the first edge following reset. The bench drives every input from time zero and changes it only on falling edges, so each edge sees settled, defined values. A load strobe that is active during reset is covered by a flag that arms the load property only after the first clock edge out of reset.

// File: rtl/bank_addr_gen.sv
module bank_addr_gen #(
  parameter int FILE_W = 8,
  parameter int PAGE_W = 4,
  parameter int REG_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [FILE_W-1:0]          file_field,
  input  logic                       page_mode,
  input  logic                       page_wr,
  input  logic [REG_W-1:0]           page_wdata,
  output logic [FILE_W+PAGE_W-1:0]   data_addr,
  output logic [REG_W-1:0]           page_q
);

  localparam int ADDR_W = FILE_W + PAGE_W;

  logic [PAGE_W-1:0] page_eff;
  logic              window_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       page_q <= '0;
    else if (page_wr) page_q <= page_wdata;

  assign window_hi = file_field[FILE_W-1];
  assign page_eff  = page_mode ? page_q[PAGE_W-1:0] : {PAGE_W{window_hi}};
  assign data_addr = {page_eff, file_field};

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_low_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_mode && file_field < FILE_W'(1 << (FILE_W-1))) |-> data_addr[ADDR_W-1:FILE_W] == '0);

  p_sfr_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_mode && file_field[FILE_W-1]) |-> &data_addr[ADDR_W-1:FILE_W-1]);

  p_paged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_mode |-> (data_addr[FILE_W-1:0] == file_field &&
                   data_addr[ADDR_W-1:FILE_W] == page_q[PAGE_W-1:0]));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && page_wr) |=> page_q == $past(page_wdata));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !page_wr) |=> $stable(page_q));

endmodule

// File: tb/bank_addr_gen_test.sv
module bank_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  file_field = '0;
  logic        page_mode = 1'b0;
  logic        page_wr = 1'b0;
  logic [7:0]  page_wdata = '0;
  logic [11:0] data_addr;
  logic [7:0]  page_q;

  always #10 clk = ~clk;

  bank_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .file_field(file_field), .page_mode(page_mode),
    .page_wr(page_wr), .page_wdata(page_wdata), .data_addr(data_addr), .page_q(page_q)
  );

  typedef struct {
    logic [11:0] addr;
    logic [7:0]  page;
    string       req;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int fails = 0;
  logic [7:0] model_page = 8'h00;
  bit done = 0;

  function automatic logic [11:0] expect_addr(logic [7:0] f, logic m, logic [7:0] pg);
    if (m) return {pg[3:0], f};
    if (f < 8'h80) return 12'h000 + f;
    return 12'hF00 + f;
  endfunction

  task automatic step(input logic [7:0] f, input logic m, input logic wr,
                      input logic [7:0] wd, input string req);
    item_t it;
    @(negedge clk);
    file_field = f; page_mode = m; page_wr = wr; page_wdata = wd;
    it.addr = expect_addr(f, m, model_page);
    it.page = model_page;
    it.req  = req;
    exp_q.push_back(it);
    if (wr) model_page = wd;
  endtask

  always @(negedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (data_addr !== it.addr || page_q !== it.page) begin
        fails++;
        $display("FAIL %s: addr=%h page=%h expected addr=%h page=%h",
                 it.req, data_addr, page_q, it.addr, it.page);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(8'h12, 1'b1, 1'b0, 8'h00, "R1");
    step(8'h00, 1'b0, 1'b0, 8'h00, "R2");
    step(8'h7F, 1'b0, 1'b0, 8'h00, "R2");
    step(8'h3C, 1'b0, 1'b0, 8'h00, "R2");
    step(8'h80, 1'b0, 1'b0, 8'h00, "R3");
    step(8'hFF, 1'b0, 1'b0, 8'h00, "R3");
    step(8'hC4, 1'b0, 1'b0, 8'h00, "R3");
    step(8'h40, 1'b1, 1'b1, 8'h02, "R5 same-cycle old page");
    step(8'h40, 1'b1, 1'b0, 8'h00, "R5 new page");
    step(8'hA7, 1'b1, 1'b0, 8'h00, "R4");
    step(8'h55, 1'b1, 1'b1, 8'h0F, "R4");
    step(8'h81, 1'b1, 1'b0, 8'h00, "R4 page 15");
    step(8'h10, 1'b0, 1'b0, 8'h00, "R2 window ignores page");
    step(8'h90, 1'b0, 1'b0, 8'h00, "R3 window ignores page");
    step(8'h33, 1'b1, 1'b1, 8'hA3, "R5");
    step(8'h33, 1'b1, 1'b0, 8'h00, "R6 upper nibble ignored");
    step(8'hF0, 1'b1, 1'b0, 8'h00, "R6");
    step(8'hF0, 1'b1, 1'b1, 8'h53, "R6 upper nibble changed");
    step(8'hF0, 1'b1, 1'b0, 8'h00, "R6 same address");
    for (int i = 0; i < 4; i++)
      step(8'(i * 37), 1'b1, 1'b0, 8'h00, "R7 hold");
    for (int b = 0; b < 16; b++) begin
      step(8'(b * 16 + 5), 1'b1, 1'b1, 8'(b), "R5 sweep load");
      step(8'(b * 16 + 5), 1'b1, 1'b0, 8'h00, "R4 sweep");
    end
    step(8'h00, 1'b0, 1'b0, 8'h00, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule